// File: doc/BRIEF.md
# Strap-Latched Frequency Mode Selector

This block sits beside the frequency synthesizer of a clock generator and decides which of sixteen frequency settings is active. At power-on it captures a set of configuration straps: three frequency-select pins, a fourth select pin that forms the top index bit, and a pin choosing the low-speed I/O clock. The pins are shared with clock outputs, so the capture happens exactly once, a fixed number of clock cycles after the active-low power-on reset is released. After that the pins are ignored until the next power-on reset.

A control byte, written over the serial bus elsewhere and presented here as a plain input, chooses whether the index comes from the captured straps or from four software bits. The same byte sets spread-spectrum enable, spread depth and a global tristate of all clock outputs. Every one of these outputs is refreshed from a single register stage, so the frequency lookup downstream never sees a half-changed index. The captured straps are also presented for readback, the frequency bits in inverted form.

Top module: `strap_freq_sel`

## Requirements
- R1: While `por_n` is low, `sel_idx` is 0, `ss_en`, `ss_wide`, `outs_hiz`, `io_24m`, `sdsel_rb` and `straps_locked` are 0, and `fs_rb_n` is 3'b111.
- R2: The straps are captured at the SETTLE_CYCLES-th rising clock edge after `por_n` goes high (default 4); `straps_locked` goes high at that same edge and stays high until the next power-on reset.
- R3: Once `straps_locked` is high, changes on `fs_pin`, `sdsel_pin` and `iosel_pin` have no effect on any output.
- R4: With `ctrl0[3]` = 0 (hardware source), `sel_idx` becomes {latched sdsel, latched fs[2], fs[1], fs[0]} one clock edge later, the select strap being the most significant bit.
- R5: With `ctrl0[3]` = 1 (software source), `sel_idx` becomes {`ctrl0[2]`, `ctrl0[6]`, `ctrl0[5]`, `ctrl0[4]`} one clock edge later.
- R6: `ss_en` follows `ctrl0[1]` and `ss_wide` (1 = ±0.5 %, 0 = ±0.25 %) follows `ctrl0[7]`, each one clock edge later.
- R7: `outs_hiz` follows `ctrl0[0]` (1 = tristate all outputs, 0 = run) one clock edge later; a control byte of 0 gives hardware select, no spread and running outputs.
- R8: `io_24m` equals the latched `iosel_pin` (0 = 14.318 MHz, 1 = 24 MHz).
- R9: `fs_rb_n` equals the bitwise inverse of the latched `fs_pin`, and `sdsel_rb` equals the latched `sdsel_pin`.
- R10: A fresh power-on reset clears the latch and captures the strap values present at the new capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| fs_pin | input | 3 | Frequency-select strap pins |
| sdsel_pin | input | 1 | Index top-bit strap pin |
| iosel_pin | input | 1 | Low-speed I/O clock strap pin |
| ctrl0 | input | 8 | Control byte from the register file |
| sel_idx | output | 4 | Frequency table index |
| ss_en | output | 1 | Spread-spectrum enable |
| ss_wide | output | 1 | Spread depth select |
| outs_hiz | output | 1 | Tristate all clock outputs |
| io_24m | output | 1 | I/O clock select, 1 = 24 MHz |
| straps_locked | output | 1 | Straps have been captured |
| fs_rb_n | output | 3 | Inverted latched frequency straps |
| sdsel_rb | output | 1 | Latched index top-bit strap |

## Verification
The hardest condition to reach is the exact capture edge: the straps are only looked at on one edge after reset release, so the stimulus holds a chosen strap pattern across the settling window, samples `straps_locked` on both sides of that edge, then scrambles the pins and shows through the readback and hardware-mode index that nothing moved. Several power-on resets with random and extreme strap patterns repeat this, and between them random control bytes flip the source bit back and forth so the index alternates between latched and software values on consecutive cycles.

// File: rtl/strap_freq_sel.sv
module strap_freq_sel #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [2:0] fs_pin,
  input  logic       sdsel_pin,
  input  logic       iosel_pin,
  input  logic [7:0] ctrl0,
  output logic [3:0] sel_idx,
  output logic       ss_en,
  output logic       ss_wide,
  output logic       outs_hiz,
  output logic       io_24m,
  output logic       straps_locked,
  output logic [2:0] fs_rb_n,
  output logic       sdsel_rb
);
  localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] settle_cnt;
  logic [2:0]    fs_q;
  logic          sdsel_q;
  logic          iosel_q;
  logic          locked_q;

  wire       src_sw  = ctrl0[3];
  wire [3:0] sw_idx  = {ctrl0[2], ctrl0[6:4]};
  wire [3:0] hw_idx  = {sdsel_q, fs_q};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      settle_cnt <= '0;
      locked_q   <= 1'b0;
      fs_q       <= '0;
      sdsel_q    <= 1'b0;
      iosel_q    <= 1'b0;
    end else if (!locked_q) begin
      if (settle_cnt == LAST) begin
        locked_q <= 1'b1;
        fs_q     <= fs_pin;
        sdsel_q  <= sdsel_pin;
        iosel_q  <= iosel_pin;
      end else begin
        settle_cnt <= settle_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sel_idx  <= '0;
      ss_en    <= 1'b0;
      ss_wide  <= 1'b0;
      outs_hiz <= 1'b0;
    end else begin
      sel_idx  <= src_sw ? sw_idx : hw_idx;
      ss_en    <= ctrl0[1];
      ss_wide  <= ctrl0[7];
      outs_hiz <= ctrl0[0];
    end
  end

  assign straps_locked = locked_q;
  assign io_24m        = iosel_q;
  assign fs_rb_n       = ~fs_q;
  assign sdsel_rb      = sdsel_q;
endmodule

// File: rtl/strap_freq_sel_chk.sv
module strap_freq_sel_chk (
  input logic       clk,
  input logic       por_n,
  input logic [2:0] fs_pin,
  input logic       sdsel_pin,
  input logic       iosel_pin,
  input logic [7:0] ctrl0,
  input logic [3:0] sel_idx,
  input logic       ss_en,
  input logic       ss_wide,
  input logic       outs_hiz,
  input logic       io_24m,
  input logic       straps_locked,
  input logic [2:0] fs_rb_n,
  input logic       sdsel_rb
);
  wire unused_pins = ^{fs_pin, sdsel_pin, iosel_pin};

  a_r1_reset_state: assert property (@(posedge clk)
    !por_n |-> (sel_idx == 4'd0 && !ss_en && !ss_wide && !outs_hiz &&
                !io_24m && !straps_locked && fs_rb_n == 3'b111 && !sdsel_rb));

  a_r2_lock_holds: assert property (@(posedge clk) disable iff (!por_n)
    $past(straps_locked) |-> straps_locked);

  a_r3_latch_stable: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && $past(straps_locked)) |->
      ($stable(fs_rb_n) && $stable(sdsel_rb) && $stable(io_24m)));

  a_r4_hw_index: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && !$past(ctrl0[3])) |->
      sel_idx == {$past(sdsel_rb), ~$past(fs_rb_n)});

  a_r5_sw_index: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && $past(ctrl0[3])) |->
      sel_idx == {$past(ctrl0[2]), $past(ctrl0[6:4])});

  a_r6_spread: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> (ss_en == $past(ctrl0[1]) && ss_wide == $past(ctrl0[7])));

  a_r7_hiz: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> outs_hiz == $past(ctrl0[0]));

  a_r8_io_unlocked: assert property (@(posedge clk) disable iff (!por_n)
    !straps_locked |-> (!io_24m && fs_rb_n == 3'b111 && !sdsel_rb && unused_pins == unused_pins));
endmodule

bind strap_freq_sel strap_freq_sel_chk chk (.*);

// File: tb/strap_freq_sel_test.sv
module strap_freq_sel_test;
  logic       clk = 1'b0;
  logic       por_n;
  logic [2:0] fs_pin;
  logic       sdsel_pin, iosel_pin;
  logic [7:0] ctrl0;
  logic [3:0] sel_idx;
  logic       ss_en, ss_wide, outs_hiz, io_24m, straps_locked, sdsel_rb;
  logic [2:0] fs_rb_n;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [2:0] e_fs;
  logic       e_sd, e_io;

  always #5 clk = ~clk;

  strap_freq_sel uut (
    .clk(clk), .por_n(por_n), .fs_pin(fs_pin), .sdsel_pin(sdsel_pin),
    .iosel_pin(iosel_pin), .ctrl0(ctrl0), .sel_idx(sel_idx), .ss_en(ss_en),
    .ss_wide(ss_wide), .outs_hiz(outs_hiz), .io_24m(io_24m),
    .straps_locked(straps_locked), .fs_rb_n(fs_rb_n), .sdsel_rb(sdsel_rb)
  );

  function automatic logic [3:0] exp_idx(logic [7:0] c, logic sd, logic [2:0] fs);
    return c[3] ? {c[2], c[6:4]} : {sd, fs};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ctrl(logic [7:0] c);
    chk(c[3] ? "R5" : "R4", sel_idx, exp_idx(c, e_sd, e_fs));
    chk("R6", {ss_wide, ss_en}, {c[7], c[1]});
    chk("R7", outs_hiz, c[0]);
  endtask

  task automatic power_on(logic [2:0] fs, logic sd, logic io);
    @(negedge clk);
    por_n = 1'b0;
    ctrl0 = $urandom;
    fs_pin = fs; sdsel_pin = sd; iosel_pin = io;
    @(negedge clk);
    chk("R1", {sel_idx, ss_en, ss_wide, outs_hiz, io_24m, straps_locked, fs_rb_n, sdsel_rb},
        {4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 1'b0});
    ctrl0 = 8'h00;
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", straps_locked, 1'b0);
    @(negedge clk);
    chk("R2", straps_locked, 1'b1);
    e_fs = fs; e_sd = sd; e_io = io;
    chk("R9", {fs_rb_n, sdsel_rb}, {~fs, sd});
    chk("R8", io_24m, io);
    @(negedge clk);
    chk("R7", {sel_idx, ss_en, ss_wide, outs_hiz}, {sd, fs, 3'b000});
    fs_pin = ~fs; sdsel_pin = ~sd; iosel_pin = ~io;
    repeat (2) @(negedge clk);
    chk("R3", {fs_rb_n, sdsel_rb, io_24m, sel_idx}, {~fs, sd, io, sd, fs});
  endtask

  task automatic random_ctrl(int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] c;
      c = $urandom;
      ctrl0 = c;
      fs_pin = $urandom; sdsel_pin = $urandom; iosel_pin = $urandom;
      @(negedge clk);
      check_ctrl(c);
      if (i % 16 == 0) chk("R3", {fs_rb_n, sdsel_rb, io_24m}, {~e_fs, e_sd, e_io});
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    por_n = 1'b0; ctrl0 = 8'h00; fs_pin = 3'b000; sdsel_pin = 1'b0; iosel_pin = 1'b0;
    power_on(3'b000, 1'b0, 1'b0);
    random_ctrl(100);
    power_on(3'b111, 1'b1, 1'b1);
    ctrl0 = 8'h08; @(negedge clk); check_ctrl(8'h08);
    ctrl0 = 8'h00; @(negedge clk); check_ctrl(8'h00);
    ctrl0 = 8'hFF; @(negedge clk); check_ctrl(8'hFF);
    ctrl0 = 8'h74; @(negedge clk); check_ctrl(8'h74);
    random_ctrl(100);
    for (int k = 0; k < 6; k++) begin
      logic [2:0] f;
      logic s, o;
      f = $urandom; s = $urandom; o = $urandom;
      power_on(f, s, o);
      chk("R10", {fs_rb_n, sdsel_rb, io_24m}, {~f, s, o});
      random_ctrl(150);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule